// File: doc/BRIEF.md
# Two-Port Bus Transceiver with Capture Registers

This block connects two 8-bit data ports, A and B, and can pass data across in either direction. Each port has its own capture register with its own capture clock. The A-side register samples the A input, and the B-side register samples the B input. An active-low output enable and a direction input choose which port, if any, is driven. For each direction, a select input chooses what that port receives: either the live input of the opposite port, or the value held in the opposite port's register.

The block does not use tri-state nets. Each port has a separate input, a separate output and a separate output-enable flag, and the pad or the on-chip bus logic combines them. A synchronous active-high reset clears each register on an edge of that register's own capture clock. Capture is never gated by the output controls, so data can be stored while both ports are isolated.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_cap_a`, the A-side register loads `a_in`. On each rising edge of `clk_cap_b`, the B-side register loads `b_in`. Each register keeps its value between edges of its own clock.
- R2: While `out_en_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both all-zero.
- R3: While `out_en_n` is 0 and `dir_a2b` is 1, only `b_oe` is 1, and `a_out` is all-zero. While `out_en_n` is 0 and `dir_a2b` is 0, only `a_oe` is 1, and `b_out` is all-zero.
- R4: When port B is driven, `use_store_to_b` = 0 makes `b_out` follow `a_in` combinationally, in the same cycle. `use_store_to_b` = 1 makes `b_out` equal the A-side register, so changes on `a_in` have no effect until the next `clk_cap_a` edge.
- R5: When port A is driven, `use_store_to_a` = 0 makes `a_out` follow `b_in` combinationally. `use_store_to_a` = 1 makes `a_out` equal the B-side register, so changes on `b_in` have no effect until the next `clk_cap_b` edge.
- R6: Captures take place whatever the values of `out_en_n`, `dir_a2b` and the select inputs. Clocking one register leaves the other register unchanged.
- R7: Both registers can capture on the same instant while a port is being driven. Each register then holds its own port's input.
- R8: `a_oe` and `b_oe` are never 1 together.
- R9: While `rst` is 1, a rising edge of a capture clock clears that clock's register to all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cap_a | input | 1 | Capture clock of the A-side register |
| clk_cap_b | input | 1 | Capture clock of the B-side register |
| rst | input | 1 | Synchronous active-high register clear |
| out_en_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir_a2b | input | 1 | 1 drives port B from the A side; 0 drives port A from the B side |
| use_store_to_b | input | 1 | Port B source: 0 live `a_in`, 1 A-side register |
| use_store_to_a | input | 1 | Port A source: 0 live `b_in`, 1 B-side register |
| a_in | input | W | Data arriving at port A |
| a_out | output | W | Data driven onto port A (zero when not enabled) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | W | Data arriving at port B |
| b_out | output | W | Data driven onto port B (zero when not enabled) |
| b_oe | output | 1 | Port B drive enable |

## Verification
The bench stores data while both ports are isolated, then reads it back through the stored path. A design that gated capture with the enable would return the old or reset value instead. After a stored value is selected, the bench changes the live input without a clock edge. A design that mixed up the live and stored selections, or swapped the two registers, would let that change through or would show the other port's data. The bench also pulses both clocks at the same instant to show that the registers do not disturb each other. Finally, it sweeps all control combinations, which catches a decoder that enables both ports or that inverts the direction.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  // Number of transfer lanes: lane 0 carries A toward B, lane 1 carries B toward A.
  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_A2B = 0;
  localparam int unsigned LANE_B2A = 1;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_PORT_A = 2'd1,
    DRV_PORT_B = 2'd2
  } drive_target_e;
endpackage

// File: rtl/regbus_xcvr_cap.sv
module regbus_xcvr_cap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Captures on every edge; the output controls have no say here.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/regbus_xcvr_ctl.sv
module regbus_xcvr_ctl
  import regbus_xcvr_pkg::*;
(
  input  logic out_en_n,
  input  logic dir_a2b,
  output logic lane_en [LANES]
);
  drive_target_e target;

  always_comb begin
    if (out_en_n)     target = DRV_NONE;
    else if (dir_a2b) target = DRV_PORT_B;
    else              target = DRV_PORT_A;
  end

  // Only one target can be chosen at a time, so at most one lane is enabled.
  assign lane_en[LANE_A2B] = (target == DRV_PORT_B);
  assign lane_en[LANE_B2A] = (target == DRV_PORT_A);
endmodule

// File: rtl/regbus_xcvr_route.sv
module regbus_xcvr_route #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic         pick_store,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout
);
  logic [W-1:0] chosen;

  assign chosen = pick_store ? stored : live;
  assign dout   = en ? chosen : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_cap_a,
  input  logic         clk_cap_b,
  input  logic         rst,
  input  logic         out_en_n,
  input  logic         dir_a2b,
  input  logic         use_store_to_b,
  input  logic         use_store_to_a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic         lane_clk  [LANES];
  logic [W-1:0] lane_src  [LANES];
  logic [W-1:0] lane_hold [LANES];
  logic [W-1:0] lane_out  [LANES];
  logic         lane_pick [LANES];
  logic         lane_en   [LANES];
  logic [W-1:0] held_a;
  logic [W-1:0] held_b;

  assign lane_clk[LANE_A2B]  = clk_cap_a;
  assign lane_clk[LANE_B2A]  = clk_cap_b;
  assign lane_src[LANE_A2B]  = a_in;
  assign lane_src[LANE_B2A]  = b_in;
  assign lane_pick[LANE_A2B] = use_store_to_b;
  assign lane_pick[LANE_B2A] = use_store_to_a;

  regbus_xcvr_ctl u_ctl (
    .out_en_n (out_en_n),
    .dir_a2b  (dir_a2b),
    .lane_en  (lane_en)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    regbus_xcvr_cap #(.W(W)) u_cap (
      .clk (lane_clk[g]),
      .rst (rst),
      .d   (lane_src[g]),
      .q   (lane_hold[g])
    );

    regbus_xcvr_route #(.W(W)) u_route (
      .en         (lane_en[g]),
      .pick_store (lane_pick[g]),
      .live       (lane_src[g]),
      .stored     (lane_hold[g]),
      .dout       (lane_out[g])
    );
  end

  assign held_a = lane_hold[LANE_A2B];
  assign held_b = lane_hold[LANE_B2A];
  assign b_out  = lane_out[LANE_A2B];
  assign b_oe   = lane_en[LANE_A2B];
  assign a_out  = lane_out[LANE_B2A];
  assign a_oe   = lane_en[LANE_B2A];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_cap_a,
  input logic         clk_cap_b,
  input logic         rst,
  input logic         out_en_n,
  input logic         use_store_to_b,
  input logic         use_store_to_a,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] held_a,
  input logic [W-1:0] held_b
);
  p_one_driver_r8: assert property (@(posedge clk_cap_a) disable iff (rst)
    !(a_oe && b_oe));

  p_isolate_r2: assert property (@(posedge clk_cap_b) disable iff (rst)
    out_en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  p_live_to_b_r4: assert property (@(posedge clk_cap_a) disable iff (rst)
    (b_oe && !use_store_to_b) |-> (b_out == a_in));

  p_stored_to_b_r4: assert property (@(posedge clk_cap_b) disable iff (rst)
    (b_oe && use_store_to_b) |-> (b_out == held_a));

  p_stored_to_a_r5: assert property (@(posedge clk_cap_a) disable iff (rst)
    (a_oe && use_store_to_a) |-> (a_out == held_b));

  p_live_to_a_r5: assert property (@(posedge clk_cap_b) disable iff (rst)
    (a_oe && !use_store_to_a) |-> (a_out == b_in));

  p_clear_a_r9: assert property (@(posedge clk_cap_a)
    rst |=> (held_a == '0));

  p_clear_b_r9: assert property (@(posedge clk_cap_b)
    rst |=> (held_b == '0));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk_cap_a      (clk_cap_a),
  .clk_cap_b      (clk_cap_b),
  .rst            (rst),
  .out_en_n       (out_en_n),
  .use_store_to_b (use_store_to_b),
  .use_store_to_a (use_store_to_a),
  .a_in           (a_in),
  .b_in           (b_in),
  .a_out          (a_out),
  .b_out          (b_out),
  .a_oe           (a_oe),
  .b_oe           (b_oe),
  .held_a         (held_a),
  .held_b         (held_b)
);

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;
  localparam int unsigned W = 8;
  localparam int unsigned WDOG_LIMIT = 20000;

  typedef struct {
    string        req;
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clk_cap_a = 1'b0;
  logic         clk_cap_b = 1'b0;
  logic         rst = 1'b1;
  logic         out_en_n = 1'b1;
  logic         dir_a2b = 1'b0;
  logic         use_store_to_b = 1'b0;
  logic         use_store_to_a = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out;
  logic [W-1:0] b_out;
  logic         a_oe;
  logic         b_oe;

  regbus_xcvr #(.W(W)) u0 (
    .clk_cap_a      (clk_cap_a),
    .clk_cap_b      (clk_cap_b),
    .rst            (rst),
    .out_en_n       (out_en_n),
    .dir_a2b        (dir_a2b),
    .use_store_to_b (use_store_to_b),
    .use_store_to_a (use_store_to_a),
    .a_in           (a_in),
    .a_out          (a_out),
    .a_oe           (a_oe),
    .b_in           (b_in),
    .b_out          (b_out),
    .b_oe           (b_oe)
  );

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  exp_t        sb_q[$];
  event        ev_check;

  // Reference register contents, built from the requirements.
  logic [W-1:0] ref_a = '0;
  logic [W-1:0] ref_b = '0;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(ev_check);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (a_oe !== e.a_oe || b_oe !== e.b_oe ||
            a_out !== e.a_out || b_out !== e.b_out) begin
          n_errors++;
          $display("FAIL %s: got a_oe=%b b_oe=%b a_out=%h b_out=%h, expected a_oe=%b b_oe=%b a_out=%h b_out=%h",
                   e.req, a_oe, b_oe, a_out, b_out, e.a_oe, e.b_oe, e.a_out, e.b_out);
        end
      end
    end
  end

  // Driver side: predicts the outputs and queues them for the monitor.
  task automatic expect_now(input string req);
    exp_t e;
    #1;
    e.req   = req;
    e.a_oe  = !out_en_n && !dir_a2b;
    e.b_oe  = !out_en_n && dir_a2b;
    e.a_out = e.a_oe ? (use_store_to_a ? ref_b : b_in) : '0;
    e.b_out = e.b_oe ? (use_store_to_b ? ref_a : a_in) : '0;
    sb_q.push_back(e);
    -> ev_check;
    #1;
  endtask

  task automatic set_ctl(input logic oen, input logic d, input logic sb, input logic sa);
    out_en_n = oen;
    dir_a2b = d;
    use_store_to_b = sb;
    use_store_to_a = sa;
  endtask

  task automatic pulse(input logic do_a, input logic do_b);
    @(negedge clk);
    if (do_a) begin clk_cap_a = 1'b1; ref_a = rst ? '0 : a_in; end
    if (do_b) begin clk_cap_b = 1'b1; ref_b = rst ? '0 : b_in; end
    #1.5;
    clk_cap_a = 1'b0;
    clk_cap_b = 1'b0;
    #0.5;
  endtask

  // Watchdog.
  int unsigned wdog = 0;
  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog == WDOG_LIMIT) begin
      n_errors++;
      $display("FAIL watchdog: got %0d cycles, expected fewer", wdog);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    // R9: reset clears both registers on their own clocks.
    a_in = 8'hE7; b_in = 8'h18;
    pulse(1'b1, 1'b1);
    rst = 1'b0;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_now("R9 stored A after reset");
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R9 stored B after reset");

    // R2: isolation under several input patterns and selects.
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    a_in = 8'hFF; b_in = 8'hFF;
    expect_now("R2 isolate dir=1 live");
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    expect_now("R2 isolate dir=0 stored");

    // R6: capture while isolated, each register on its own.
    a_in = 8'h3C; b_in = 8'hA5;
    pulse(1'b1, 1'b0);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_now("R6 A captured while isolated");
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R6 B untouched by A capture");
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    b_in = 8'h5A; a_in = 8'h00;
    pulse(1'b0, 1'b1);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R6 B captured while isolated");
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_now("R6 A untouched by B capture");

    // R3: direction picks exactly one driven port.
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'h81; b_in = 8'h42;
    expect_now("R3 dir=1 drives B only");
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    expect_now("R3 dir=0 drives A only");

    // R4: live path follows a_in, stored path holds until clk_cap_a.
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    foreach (a_in[i]) begin end
    a_in = 8'h00; expect_now("R4 live 00");
    a_in = 8'hFF; expect_now("R4 live FF");
    a_in = 8'h96; expect_now("R4 live 96");
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    expect_now("R4 stored before change");
    a_in = 8'h69;
    expect_now("R4 stored ignores a_in change");
    pulse(1'b1, 1'b0);
    expect_now("R4 stored after clk_cap_a");

    // R5: mirror for port A.
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    b_in = 8'h11; expect_now("R5 live 11");
    b_in = 8'hEE; expect_now("R5 live EE");
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    b_in = 8'h24;
    expect_now("R5 stored ignores b_in change");
    pulse(1'b0, 1'b1);
    expect_now("R5 stored after clk_cap_b");

    // R7: simultaneous capture while port B is driven.
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'hC3; b_in = 8'h7E;
    pulse(1'b1, 1'b1);
    a_in = 8'h00; b_in = 8'h00;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    expect_now("R7 A after joint capture");
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_now("R7 B after joint capture");

    // R1: a run of captures through each register.
    for (int k = 0; k < 4; k++) begin
      a_in = 8'(8'h17 * (k + 1));
      b_in = 8'(8'hB3 ^ (k << 2));
      pulse(1'b1, 1'b1);
      set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
      expect_now("R1 A capture sequence");
      set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
      expect_now("R1 B capture sequence");
    end

    // R8: every control combination enables at most one port.
    for (int c = 0; c < 16; c++) begin
      set_ctl(c[0], c[1], c[2], c[3]);
      a_in = 8'(c * 13);
      b_in = 8'(c * 29);
      expect_now("R8 control sweep");
      if (a_oe && b_oe) begin
        n_errors++;
        $display("FAIL R8: got a_oe=1 b_oe=1, expected at most one");
      end
    end

    #5;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule